// File: doc/BRIEF.md
# Single-Entry Delayed Store Buffer for a Direct-Mapped Data Cache

This block sits between a processor load/store port and a direct-mapped data cache. The cache's tag array and data array have separate read and write addressing. Each store has its tag checked in the cycle it is presented. The block does not write the data array in that cycle. It keeps the store's address, data, byte mask and hit result in a single pending entry. That entry is written to the data array during the tag check of the next store, so every store uses only one pipeline slot.

Loads to the address held in the pending entry read through a bypass. The pending bytes are merged over the word read from the array. A flush request drains the entry in the next idle cycle. A store that missed in the tag array is never written, because the cache does not allocate on a write miss. Refilling lines from lower memory is outside this block.

A request address is a word address. The low `IDX_W` bits select the line and the upper `TAG_W` bits are the tag. Tag and data arrays are read combinationally in the request cycle, and responses appear in that same cycle.

Top module: `store_defer_buf`

## Requirements
- R1: A request's hit result is computed in the cycle it is presented: `rsp_hit` is 1 when the tag array entry at the request's index is valid and holds the request's tag (upper `TAG_W` bits of `req_addr`). Otherwise `rsp_miss` is 1. A store issues no data write in its own request cycle.
- R2: When a store arrives while a hitting store is pending, the pending store is written in that same cycle. The write uses the pending store's index, data and byte mask, and the new store then becomes the pending entry.
- R3: A pending store whose tag check missed is discarded without any data array write.
- R4: A load whose address equals a pending store that hit reports a hit. Its data takes each byte (bit 8k+7..8k for mask bit k) from the pending store when that mask bit is 1, and from the data array otherwise.
- R5: A load whose address equals a pending store that missed follows the tag array result and returns the unmerged array word.
- R6: A `flush` pulse makes the pending store (if it hit) be written in the next cycle with no request, and afterwards the buffer is empty, so the next store issues no write.
- R7: After reset the buffer is empty and no data write is issued until a hitting store is followed by another store or a flush drain.
- R8: Loads never cause a data write and leave the pending entry in place.
- R9: A load whose address differs from the pending store's address returns the data array word unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | TAG_W+IDX_W | Word address, {tag, index} |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte mask |
| flush | input | 1 | Request draining of the pending store |
| rsp_hit | output | 1 | Request hit |
| rsp_miss | output | 1 | Request missed |
| rsp_rdata | output | DATA_W | Load data |
| tag_rd_idx | output | IDX_W | Tag array read index |
| tag_rd_tag | input | TAG_W | Tag stored at `tag_rd_idx` |
| tag_rd_valid | input | 1 | Valid bit at `tag_rd_idx` |
| data_rd_idx | output | IDX_W | Data array read index |
| data_rd_data | input | DATA_W | Word stored at `data_rd_idx` |
| data_wr_en | output | 1 | Data array write strobe |
| data_wr_idx | output | IDX_W | Data array write index |
| data_wr_data | output | DATA_W | Data array write word |
| data_wr_be | output | DATA_W/8 | Data array write byte mask |

## Verification
The assertions assume the tag and data arrays return the contents at the presented index within the same cycle. They also assume the tag array does not change between a store's tag check and the write of that store. The bench models both arrays as combinational-read memories that are written on the clock edge. It preloads the tags once and never refills during a run, so this assumption always holds. Inputs change only at the falling edge, and responses are sampled shortly after, before the next rising edge.

// File: rtl/store_defer_buf.sv
`timescale 1ns/1ps
module store_defer_buf #(
  parameter int TAG_W  = 6,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int AW    = TAG_W + IDX_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              flush,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  input  logic              tag_rd_valid,
  output logic [IDX_W-1:0]  data_rd_idx,
  input  logic [DATA_W-1:0] data_rd_data,
  output logic              data_wr_en,
  output logic [IDX_W-1:0]  data_wr_idx,
  output logic [DATA_W-1:0] data_wr_data,
  output logic [BE_W-1:0]   data_wr_be
);
  logic              pend_valid, pend_hit, flush_armed;
  logic [AW-1:0]     pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [BE_W-1:0]   pend_be;

  logic is_store, is_load, idle, drain, tag_hit, byp_hit;
  logic [DATA_W-1:0] merged;

  assign is_store = req_valid && req_store;
  assign is_load  = req_valid && !req_store;
  assign idle     = !req_valid;
  assign drain    = flush_armed && idle;

  assign tag_rd_idx  = req_addr[IDX_W-1:0];
  assign data_rd_idx = req_addr[IDX_W-1:0];
  assign tag_hit     = tag_rd_valid && (tag_rd_tag == req_addr[AW-1:IDX_W]);
  assign byp_hit     = is_load && pend_valid && pend_hit && (pend_addr == req_addr);

  always_comb begin
    for (int b = 0; b < BE_W; b++)
      merged[8*b +: 8] = pend_be[b] ? pend_data[8*b +: 8] : data_rd_data[8*b +: 8];
  end

  assign rsp_hit   = req_valid && (byp_hit || tag_hit);
  assign rsp_miss  = req_valid && !rsp_hit;
  assign rsp_rdata = byp_hit ? merged : data_rd_data;

  assign data_wr_en   = pend_valid && pend_hit && (is_store || drain);
  assign data_wr_idx  = pend_addr[IDX_W-1:0];
  assign data_wr_data = pend_data;
  assign data_wr_be   = pend_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid  <= 1'b0;
      pend_hit    <= 1'b0;
      flush_armed <= 1'b0;
      pend_addr   <= '0;
      pend_data   <= '0;
      pend_be     <= '0;
    end else begin
      if (is_store) begin
        pend_valid <= 1'b1;
        pend_hit   <= tag_hit;
        pend_addr  <= req_addr;
        pend_data  <= req_wdata;
        pend_be    <= req_be;
      end else if (drain) begin
        pend_valid <= 1'b0;
      end
      if (drain)      flush_armed <= 1'b0;
      else if (flush) flush_armed <= 1'b1;
    end
  end

  assert_wr_from_hit_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_en |-> (pend_valid && pend_hit));
  assert_wr_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_en |-> (idle || req_store));
  assert_load_no_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> !data_wr_en);
  assert_store_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> pend_valid);
  assert_drain_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drain |=> !pend_valid);
  assert_byp_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && pend_valid && pend_hit && pend_addr == req_addr) |-> (rsp_hit && !rsp_miss));
  assert_empty_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> !data_wr_en);
endmodule

// File: tb/store_defer_buf_tb_top.sv
`timescale 1ns/1ps
module store_defer_buf_tb_top;
  localparam int TAG_W = 6, IDX_W = 4, DATA_W = 32, AW = TAG_W + IDX_W, BE_W = DATA_W / 8;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_store = 0, flush = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [BE_W-1:0] req_be = '0;
  logic rsp_hit, rsp_miss, data_wr_en, tag_rd_valid;
  logic [DATA_W-1:0] rsp_rdata, data_rd_data, data_wr_data;
  logic [IDX_W-1:0] tag_rd_idx, data_rd_idx, data_wr_idx;
  logic [TAG_W-1:0] tag_rd_tag;
  logic [BE_W-1:0] data_wr_be;

  logic [TAG_W-1:0]  tmem [16];
  logic              vmem [16];
  logic [DATA_W-1:0] dmem [16];
  assign tag_rd_tag   = tmem[tag_rd_idx];
  assign tag_rd_valid = vmem[tag_rd_idx];
  assign data_rd_data = dmem[data_rd_idx];
  always @(posedge clk)
    if (data_wr_en)
      for (int b = 0; b < BE_W; b++)
        if (data_wr_be[b]) dmem[data_wr_idx][8*b +: 8] <= data_wr_data[8*b +: 8];

  store_defer_buf #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk, .rst_n, .req_valid, .req_store, .req_addr, .req_wdata, .req_be, .flush,
    .rsp_hit, .rsp_miss, .rsp_rdata, .tag_rd_idx, .tag_rd_tag, .tag_rd_valid,
    .data_rd_idx, .data_rd_data, .data_wr_en, .data_wr_idx, .data_wr_data, .data_wr_be);

  int checks = 0, failures = 0;
  bit done = 0;
  logic c_hit, c_miss, c_wen;
  logic [DATA_W-1:0] c_rdata, c_wdata;
  logic [IDX_W-1:0] c_widx;
  logic [BE_W-1:0] c_wbe;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit st, input logic [AW-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be, input bit fl);
    req_valid = v; req_store = st; req_addr = a; req_wdata = d; req_be = be; flush = fl;
    #2;
    c_hit = rsp_hit; c_miss = rsp_miss; c_rdata = rsp_rdata;
    c_wen = data_wr_en; c_widx = data_wr_idx; c_wdata = data_wr_data; c_wbe = data_wr_be;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [AW-1:0] ad(input int t, input int i);
    return {TAG_W'(t), IDX_W'(i)};
  endfunction

  task automatic t_reset;
    step(0, 0, '0, '0, '0, 0);
    chk(c_wen == 0, "R7 idle after reset", c_wen, 0);
    step(1, 1, ad(3, 1), 32'hAABBCCDD, 4'hF, 0);
    chk(c_hit == 1 && c_miss == 0, "R1 store hit", {c_hit, c_miss}, 2'b10);
    chk(c_wen == 0, "R7 R1 first store no write", c_wen, 0);
  endtask

  task automatic t_store_chain;
    step(1, 1, ad(3, 2), 32'h11223344, 4'h3, 0);
    chk(c_wen == 1 && c_widx == 1, "R2 deferred write idx", {c_wen, c_widx}, {1'b1, 4'd1});
    chk(c_wdata == 32'hAABBCCDD && c_wbe == 4'hF, "R2 deferred data/mask", {c_wdata, c_wbe}, {32'hAABBCCDD, 4'hF});
    step(0, 0, '0, '0, '0, 0);
    chk(c_wen == 0, "R2 idle without flush no write", c_wen, 0);
  endtask

  task automatic t_load_bypass;
    step(1, 0, ad(3, 2), '0, '0, 0);
    chk(c_hit == 1, "R4 bypass hit", c_hit, 1);
    chk(c_rdata == 32'h10003344, "R4 byte merge", c_rdata, 32'h10003344);
    chk(c_wen == 0, "R8 load no write", c_wen, 0);
    step(1, 0, ad(3, 1), '0, '0, 0);
    chk(c_rdata == 32'hAABBCCDD && c_hit == 1, "R9 unmatched load from array", c_rdata, 32'hAABBCCDD);
    step(1, 0, ad(4, 2), '0, '0, 0);
    chk(c_miss == 1 && c_rdata == 32'h10000002, "R9 R1 same index other tag", {c_miss, c_rdata}, {1'b1, 32'h10000002});
  endtask

  task automatic t_flush;
    step(0, 0, '0, '0, '0, 1);
    chk(c_wen == 0, "R6 flush cycle itself", c_wen, 0);
    step(0, 0, '0, '0, '0, 0);
    chk(c_wen == 1 && c_widx == 2 && c_wbe == 4'h3 && c_wdata == 32'h11223344, "R6 drain write",
        {c_wen, c_widx, c_wbe, c_wdata}, {1'b1, 4'd2, 4'h3, 32'h11223344});
    step(1, 0, ad(3, 2), '0, '0, 0);
    chk(c_rdata == 32'h10003344, "R6 drained data in array", c_rdata, 32'h10003344);
    step(1, 1, ad(3, 1), 32'h55667788, 4'hF, 0);
    chk(c_wen == 0, "R6 buffer empty after drain", c_wen, 0);
  endtask

  task automatic t_miss;
    step(1, 1, ad(7, 1), 32'hDEADBEEF, 4'hF, 0);
    chk(c_miss == 1 && c_hit == 0, "R1 R3 store miss flagged", {c_hit, c_miss}, 2'b01);
    chk(c_wen == 1 && c_wdata == 32'h55667788, "R2 hit entry written on miss store", {c_wen, c_wdata}, {1'b1, 32'h55667788});
    step(1, 0, ad(7, 1), '0, '0, 0);
    chk(c_miss == 1 && c_rdata == 32'h55667788, "R5 match missed entry", {c_miss, c_rdata}, {1'b1, 32'h55667788});
    step(1, 1, ad(3, 1), 32'h00000000, 4'hF, 0);
    chk(c_wen == 0, "R3 missed store dropped", c_wen, 0);
    step(1, 0, ad(3, 1), '0, '0, 0);
    chk(c_rdata == 32'h0 && c_hit == 1, "R4 full-mask bypass", c_rdata, 32'h0);
    step(1, 0, ad(5, 5), '0, '0, 0);
    chk(c_miss == 1, "R1 invalid line miss", c_miss, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      tmem[i] = 6'd3; vmem[i] = (i != 5); dmem[i] = 32'h10000000 + i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    step(0, 0, '0, '0, '0, 0);
    chk(c_wen == 0 && c_hit == 0 && c_miss == 0, "R7 reset outputs quiet", {c_wen, c_hit, c_miss}, 0);
    rst_n = 1;
    t_reset;
    t_store_chain;
    t_load_bypass;
    t_flush;
    t_miss;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule